// File: doc/BRIEF.md
# Interrupt Acknowledge and Completion Tracker

This block serves one processor's acknowledge reads and end-of-interrupt writes. An acknowledge either grants the highest-pending interrupt or returns the spurious ID 1023. When it grants, the block asks the pending logic to clear the interrupt. It records the interrupt that was running as the new interrupt's predecessor. The granted interrupt becomes the running interrupt, with its own priority as the running priority.

The per-interrupt predecessor entries form a chain of pre-empted interrupts. An end-of-interrupt for the running interrupt pops it. The predecessor then takes over as the running ID, and the predecessor's priority becomes the running priority.

Completion need not follow nesting order. An end-of-interrupt for an interrupt buried in the chain starts a walk down the chain, one link per cycle. If the walk finds the interrupt, it splices it out. While the walk runs, the block reports busy.

Arbitration among pending interrupts and the register decode sit outside the block.

Top module: `actrk_tracker`

## Requirements
- R1: An acknowledge returns 1023 on `ack_data` and changes neither the running ID nor the running priority in either of these cases: the highest-pending ID is 1023 or at or beyond NUM_IRQ, or its priority is not strictly below the running priority.
- R2: A granted acknowledge returns the ID in bits 9:0 of `ack_data`, one cycle after `ack_req`. In that same cycle the running ID becomes the granted ID and the running priority becomes `hp_prio`.
- R3: A granted acknowledge of an ID of 16 or above raises `pclr_valid` with that ID, unless `hp_line_high` is set. When `hp_line_high` is set, no clear is requested and the source stays pending.
- R4: For a software-generated interrupt (ID below 16), bits 12:10 of `ack_data` hold the index of the lowest set bit of `hp_sgi_src`.
- R5: For a granted software-generated interrupt, `sgi_clr_mask` is one-hot on that source bit. `pclr_valid` rises only if no other source bit remains set.
- R6: An end-of-interrupt uses only bits 9:0 of `eoi_data`. It is ignored in any of these cases: the ID is at or beyond NUM_IRQ (this covers 1023), the running ID is 1023, or `ack_req` is high in the same cycle.
- R7: An end-of-interrupt naming the running ID restores that interrupt's predecessor as the running ID one cycle later. The running priority becomes the predecessor's priority, or 0x100 when the predecessor is 1023. The running ID is 1023 exactly when the running priority is 0x100.
- R8: An end-of-interrupt naming another ID sets `busy` and walks the chain from the running ID. It stops at 1023. If it finds the ID, it unlinks it, so that later pops skip it. The running ID and priority stay unchanged throughout.
- R9: While `busy` is high, an acknowledge returns 1023 and changes no state.
- R10: After reset the running ID is 1023, the running priority is 0x100, and `busy`, `ack_valid`, `pclr_valid` and `sgi_clr_mask` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ack_req | input | 1 | Acknowledge read strobe |
| hp_id | input | 10 | Highest-pending interrupt ID |
| hp_prio | input | 8 | Priority of the highest-pending interrupt |
| hp_line_high | input | 1 | Highest-pending source is level type with its line still high |
| hp_sgi_src | input | NUM_CPU | Source bitmap for a software-generated highest-pending ID |
| eoi_req | input | 1 | End-of-interrupt write strobe |
| eoi_data | input | 32 | End-of-interrupt write value |
| prio_flat | input | NUM_IRQ*8 | Packed per-interrupt priorities |
| ack_valid | output | 1 | Acknowledge result valid |
| ack_data | output | 32 | Acknowledge result value |
| pclr_valid | output | 1 | Pending-clear request |
| pclr_id | output | 10 | ID whose pending state is to be cleared |
| sgi_clr_mask | output | NUM_CPU | Source bit to drop from the software interrupt bitmap |
| run_id | output | 10 | Running interrupt ID |
| run_prio | output | 9 | Running priority (0x100 when idle) |
| busy | output | 1 | Chain walk in progress |

## Verification
The hardest state to reach is a chain walk that actually splices an entry out of the middle. To get there, the stimulus first nests four acknowledges with strictly falling priorities, so the chain is four deep. It then completes an interior entry. The splice shows only later, as a chain of pops that skips the removed interrupt.

A second chain completes its deepest entry. This makes the walk last three cycles, and an acknowledge is issued while `busy` is still high. An end-of-interrupt for an ID absent from the chain must leave the whole pop sequence unchanged.

// File: rtl/actrk_pkg.sv
package actrk_pkg;
  localparam int ID_W      = 10;
  localparam int PRIO_W    = 8;
  localparam int RPRIO_W   = PRIO_W + 1;
  localparam int ACK_W     = 32;
  localparam int SRCF_W    = 3;
  localparam logic [ID_W-1:0]    IDLE_ID   = 10'd1023;
  localparam logic [RPRIO_W-1:0] IDLE_PRIO = 9'h100;

  typedef enum logic {WALK_IDLE, WALK_RUN} walk_st_t;
endpackage

// File: rtl/actrk_lowbit.sv
module actrk_lowbit #(
  parameter int N = 8,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] vec,
  output logic [W-1:0] idx,
  output logic         any
);
  always_comb begin
    idx = '0;
    any = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        idx = W'(i);
        any = 1'b1;
      end
    end
  end
endmodule

// File: rtl/actrk_ack_decode.sv
module actrk_ack_decode
  import actrk_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int NUM_CPU = 8,
  parameter int NUM_SGI = 16
) (
  input  logic                ack_req,
  input  logic                busy,
  input  logic [ID_W-1:0]     hp_id,
  input  logic [PRIO_W-1:0]   hp_prio,
  input  logic [RPRIO_W-1:0]  run_prio,
  input  logic                hp_line_high,
  input  logic [NUM_CPU-1:0]  hp_sgi_src,
  output logic                grant,
  output logic [ACK_W-1:0]    ack_word,
  output logic                pclr_en,
  output logic [NUM_CPU-1:0]  sgi_mask
);
  localparam int SRC_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1;
  localparam logic [ID_W-1:0] NIRQ_ID = ID_W'(NUM_IRQ);
  localparam logic [ID_W-1:0] NSGI_ID = ID_W'(NUM_SGI);

  logic [SRC_W-1:0]   src_idx;
  logic               src_any;
  logic               id_ok;
  logic               is_sgi;
  logic [SRCF_W-1:0]  src_field;
  logic [NUM_CPU-1:0] src_bit;

  actrk_lowbit #(.N(NUM_CPU)) u_low (
    .vec (hp_sgi_src),
    .idx (src_idx),
    .any (src_any)
  );

  always_comb begin
    id_ok     = (hp_id < NIRQ_ID);
    is_sgi    = (hp_id < NSGI_ID);
    grant     = ack_req && !busy && id_ok && ({1'b0, hp_prio} < run_prio);
    src_bit   = src_any ? (NUM_CPU'(1) << src_idx) : '0;
    src_field = is_sgi ? SRCF_W'(src_idx) : '0;
    if (grant) begin
      ack_word = {{(ACK_W - SRCF_W - ID_W){1'b0}}, src_field, hp_id};
    end else begin
      ack_word = {{(ACK_W - ID_W){1'b0}}, IDLE_ID};
    end
    if (is_sgi) begin
      pclr_en  = grant && ((hp_sgi_src & ~src_bit) == '0);
      sgi_mask = grant ? src_bit : '0;
    end else begin
      pclr_en  = grant && !hp_line_high;
      sgi_mask = '0;
    end
  end
endmodule

// File: rtl/actrk_unlink_fsm.sv
module actrk_unlink_fsm
  import actrk_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  localparam int IDX_W = $clog2(NUM_IRQ)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [IDX_W-1:0] start_idx,
  input  logic [ID_W-1:0]  target_id,
  input  logic [ID_W-1:0]  pred_of_cur,
  output logic             busy,
  output logic [IDX_W-1:0] cur_idx,
  output logic [IDX_W-1:0] tgt_idx,
  output logic             splice_we
);
  walk_st_t         st_q, st_d;
  logic [IDX_W-1:0] cur_q, cur_d;
  logic [ID_W-1:0]  tgt_q, tgt_d;

  always_comb begin
    st_d      = st_q;
    cur_d     = cur_q;
    tgt_d     = tgt_q;
    splice_we = 1'b0;
    unique case (st_q)
      WALK_IDLE: begin
        if (start) begin
          st_d  = WALK_RUN;
          cur_d = start_idx;
          tgt_d = target_id;
        end
      end
      WALK_RUN: begin
        if (pred_of_cur == IDLE_ID) begin
          st_d = WALK_IDLE;
        end else if (pred_of_cur == tgt_q) begin
          splice_we = 1'b1;
          st_d      = WALK_IDLE;
        end else begin
          cur_d = pred_of_cur[IDX_W-1:0];
        end
      end
      default: st_d = WALK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= WALK_IDLE;
      cur_q <= '0;
      tgt_q <= '0;
    end else begin
      st_q  <= st_d;
      cur_q <= cur_d;
      tgt_q <= tgt_d;
    end
  end

  assign busy    = (st_q == WALK_RUN);
  assign cur_idx = cur_q;
  assign tgt_idx = tgt_q[IDX_W-1:0];

  AST_START_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy); // R8
  AST_START_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy); // R8
endmodule

// File: rtl/actrk_tracker.sv
module actrk_tracker
  import actrk_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int NUM_CPU = 8,
  parameter int NUM_SGI = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ack_req,
  input  logic [ID_W-1:0]           hp_id,
  input  logic [PRIO_W-1:0]         hp_prio,
  input  logic                      hp_line_high,
  input  logic [NUM_CPU-1:0]        hp_sgi_src,
  input  logic                      eoi_req,
  input  logic [31:0]               eoi_data,
  input  logic [NUM_IRQ*PRIO_W-1:0] prio_flat,
  output logic                      ack_valid,
  output logic [ACK_W-1:0]          ack_data,
  output logic                      pclr_valid,
  output logic [ID_W-1:0]           pclr_id,
  output logic [NUM_CPU-1:0]        sgi_clr_mask,
  output logic [ID_W-1:0]           run_id,
  output logic [RPRIO_W-1:0]        run_prio,
  output logic                      busy
);
  localparam int IDX_W = $clog2(NUM_IRQ);
  localparam logic [ID_W-1:0] NIRQ_ID = ID_W'(NUM_IRQ);

  logic [PRIO_W-1:0]  prio_arr [NUM_IRQ];
  logic [ID_W-1:0]    pred_q   [NUM_IRQ];
  logic [ID_W-1:0]    run_id_q, run_id_d;
  logic [RPRIO_W-1:0] run_prio_q, run_prio_d;
  logic               run_en;

  logic               grant, pclr_en;
  logic [ACK_W-1:0]   ack_word;
  logic [NUM_CPU-1:0] sgi_mask;

  logic [ID_W-1:0]    eoi_id;
  logic               eoi_ok, pop, walk_start;
  logic [ID_W-1:0]    pred_top;
  logic [RPRIO_W-1:0] pop_prio;
  logic [IDX_W-1:0]   cur_idx, tgt_idx;
  logic               splice_we;
  logic               unused_eoi_hi;

  genvar g;
  generate
    for (g = 0; g < NUM_IRQ; g++) begin : g_prio
      assign prio_arr[g] = prio_flat[g*PRIO_W +: PRIO_W];
    end
  endgenerate

  actrk_ack_decode #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU), .NUM_SGI(NUM_SGI)) u_dec (
    .ack_req      (ack_req),
    .busy         (busy),
    .hp_id        (hp_id),
    .hp_prio      (hp_prio),
    .run_prio     (run_prio_q),
    .hp_line_high (hp_line_high),
    .hp_sgi_src   (hp_sgi_src),
    .grant        (grant),
    .ack_word     (ack_word),
    .pclr_en      (pclr_en),
    .sgi_mask     (sgi_mask)
  );

  actrk_unlink_fsm #(.NUM_IRQ(NUM_IRQ)) u_walk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (walk_start),
    .start_idx   (run_id_q[IDX_W-1:0]),
    .target_id   (eoi_id),
    .pred_of_cur (pred_q[cur_idx]),
    .busy        (busy),
    .cur_idx     (cur_idx),
    .tgt_idx     (tgt_idx),
    .splice_we   (splice_we)
  );

  assign unused_eoi_hi = ^eoi_data[31:ID_W];

  always_comb begin
    eoi_id     = eoi_data[ID_W-1:0];
    eoi_ok     = eoi_req && !busy && !ack_req && (eoi_id < NIRQ_ID) && (run_id_q != IDLE_ID);
    pop        = eoi_ok && (eoi_id == run_id_q);
    walk_start = eoi_ok && !pop;
    pred_top   = pred_q[run_id_q[IDX_W-1:0]];
    pop_prio   = (pred_top == IDLE_ID) ? IDLE_PRIO : {1'b0, prio_arr[pred_top[IDX_W-1:0]]};
    run_en     = grant || pop;
    run_id_d   = run_id_q;
    run_prio_d = run_prio_q;
    if (grant) begin
      run_id_d   = hp_id;
      run_prio_d = {1'b0, hp_prio};
    end else if (pop) begin
      run_id_d   = pred_top;
      run_prio_d = pop_prio;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_id_q   <= IDLE_ID;
      run_prio_q <= IDLE_PRIO;
    end else if (run_en) begin
      run_id_q   <= run_id_d;
      run_prio_q <= run_prio_d;
    end
  end

  always_ff @(posedge clk) begin
    if (grant) begin
      pred_q[hp_id[IDX_W-1:0]] <= run_id_q;
    end else if (splice_we) begin
      pred_q[cur_idx] <= pred_q[tgt_idx];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_valid    <= 1'b0;
      ack_data     <= '0;
      pclr_valid   <= 1'b0;
      pclr_id      <= IDLE_ID;
      sgi_clr_mask <= '0;
    end else begin
      ack_valid    <= ack_req;
      pclr_valid   <= pclr_en;
      sgi_clr_mask <= sgi_mask;
      if (ack_req) begin
        ack_data <= ack_word;
      end
      if (pclr_en) begin
        pclr_id <= hp_id;
      end
    end
  end

  assign run_id   = run_id_q;
  assign run_prio = run_prio_q;

  AST_REJECT_HOLDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req && (hp_id >= NIRQ_ID) && !eoi_req) |=> ($stable(run_id) && ack_data[ID_W-1:0] == IDLE_ID)); // R1
  AST_GRANT_LOADS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req && !busy && (hp_id < NIRQ_ID) && ({1'b0, hp_prio} < run_prio))
      |=> (run_id == $past(hp_id) && run_prio == {1'b0, $past(hp_prio)})); // R2
  AST_IDLE_PAIRING: assert property (@(posedge clk) disable iff (!rst_n)
    (run_id == IDLE_ID) == (run_prio == IDLE_PRIO)); // R7
  AST_EOI_BAD_ID_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_req && !ack_req && (eoi_data[ID_W-1:0] >= NIRQ_ID)) |=> $stable(run_id)); // R6
  AST_WALK_HOLDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ack_req) |=> $stable(run_id)); // R8
  AST_BUSY_ACK_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ack_req) |=> (ack_data[ID_W-1:0] == IDLE_ID)); // R9
  AST_SRC_CLR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sgi_clr_mask)); // R5
endmodule

// File: tb/sim_actrk_tracker.sv
module sim_actrk_tracker;
  localparam int NIRQ = 64;
  localparam int NCPU = 8;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             ack_req;
  logic [9:0]       hp_id;
  logic [7:0]       hp_prio;
  logic             hp_line_high;
  logic [NCPU-1:0]  hp_sgi_src;
  logic             eoi_req;
  logic [31:0]      eoi_data;
  logic [NIRQ*8-1:0] prio_flat;
  logic             ack_valid;
  logic [31:0]      ack_data;
  logic             pclr_valid;
  logic [9:0]       pclr_id;
  logic [NCPU-1:0]  sgi_clr_mask;
  logic [9:0]       run_id;
  logic [8:0]       run_prio;
  logic             busy;

  logic [7:0] ptab [NIRQ];
  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  always_comb begin
    for (int i = 0; i < NIRQ; i++) prio_flat[i*8 +: 8] = ptab[i];
  end

  actrk_tracker #(.NUM_IRQ(NIRQ), .NUM_CPU(NCPU), .NUM_SGI(16)) u0 (
    .clk(clk), .rst_n(rst_n), .ack_req(ack_req), .hp_id(hp_id), .hp_prio(hp_prio),
    .hp_line_high(hp_line_high), .hp_sgi_src(hp_sgi_src), .eoi_req(eoi_req),
    .eoi_data(eoi_data), .prio_flat(prio_flat), .ack_valid(ack_valid),
    .ack_data(ack_data), .pclr_valid(pclr_valid), .pclr_id(pclr_id),
    .sgi_clr_mask(sgi_clr_mask), .run_id(run_id), .run_prio(run_prio), .busy(busy)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_ack(input logic [9:0] id, input logic [7:0] pr,
                        input logic [NCPU-1:0] src, input logic lh);
    @(negedge clk);
    hp_id = id; hp_prio = pr; hp_sgi_src = src; hp_line_high = lh;
    if (id < 10'(NIRQ)) ptab[id[5:0]] = pr;
    ack_req = 1'b1;
    @(negedge clk);
    ack_req = 1'b0;
  endtask

  task automatic do_eoi(input logic [31:0] v);
    @(negedge clk);
    eoi_data = v; eoi_req = 1'b1;
    @(negedge clk);
    eoi_req = 1'b0;
  endtask

  task automatic wait_free();
    for (int k = 0; k < 200 && busy; k++) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R10 run_id", 32'(run_id), 32'd1023);
    chk("R10 run_prio", 32'(run_prio), 32'h100);
    chk("R10 busy", 32'(busy), 32'd0);
    chk("R10 ack_valid", 32'(ack_valid), 32'd0);
    chk("R10 pclr_valid", 32'(pclr_valid), 32'd0);
    chk("R10 sgi_clr_mask", 32'(sgi_clr_mask), 32'd0);
  endtask

  task automatic t_nest();
    do_ack(10'd1023, 8'h10, '0, 1'b0);
    chk("R1 spurious id", ack_data, 32'd1023);
    chk("R1 run unchanged", 32'(run_id), 32'd1023);
    do_ack(10'd40, 8'h80, '0, 1'b0);
    chk("R2 ack value", ack_data, 32'd40);
    chk("R2 ack_valid", 32'(ack_valid), 32'd1);
    chk("R2 run_id", 32'(run_id), 32'd40);
    chk("R2 run_prio", 32'(run_prio), 32'h80);
    chk("R3 pclr_valid", 32'(pclr_valid), 32'd1);
    chk("R3 pclr_id", 32'(pclr_id), 32'd40);
    do_ack(10'd35, 8'h40, '0, 1'b0);
    chk("R2 nested run_id", 32'(run_id), 32'd35);
    do_ack(10'd50, 8'h40, '0, 1'b0);
    chk("R1 equal prio rejected", ack_data, 32'd1023);
    chk("R1 equal prio run kept", 32'(run_id), 32'd35);
    chk("R1 equal prio prio kept", 32'(run_prio), 32'h40);
    do_eoi(32'hFFFF_FC00 | 32'd35);
    chk("R6 masked eoi pops", 32'(run_id), 32'd40);
    chk("R7 restored prio", 32'(run_prio), 32'h80);
    do_eoi(32'd1023);
    chk("R6 eoi 1023 ignored", 32'(run_id), 32'd40);
    do_eoi(32'd64);
    chk("R6 eoi beyond count ignored", 32'(run_id), 32'd40);
    chk("R6 no walk started", 32'(busy), 32'd0);
    do_eoi(32'd40);
    chk("R7 back to idle id", 32'(run_id), 32'd1023);
    chk("R7 idle prio", 32'(run_prio), 32'h100);
    do_eoi(32'd40);
    chk("R6 eoi while idle ignored", 32'(run_id), 32'd1023);
    chk("R6 eoi while idle no busy", 32'(busy), 32'd0);
  endtask

  task automatic t_level();
    do_ack(10'd33, 8'h30, '0, 1'b1);
    chk("R3 level high no clear", 32'(pclr_valid), 32'd0);
    chk("R3 level ack value", ack_data, 32'd33);
    do_eoi(32'd33);
    chk("R7 level eoi idle", 32'(run_id), 32'd1023);
  endtask

  task automatic t_sgi();
    do_ack(10'd3, 8'h10, 8'b0010_0100, 1'b0);
    chk("R4 source field", ack_data, 32'h803);
    chk("R5 source clear mask", 32'(sgi_clr_mask), 32'h04);
    chk("R5 other source keeps pending", 32'(pclr_valid), 32'd0);
    do_eoi(32'd3);
    do_ack(10'd3, 8'h10, 8'b0010_0000, 1'b0);
    chk("R4 source field 5", ack_data, 32'h1403);
    chk("R5 last source clear mask", 32'(sgi_clr_mask), 32'h20);
    chk("R5 last source clears pending", 32'(pclr_valid), 32'd1);
    do_eoi(32'd3);
    chk("R7 sgi eoi idle", 32'(run_id), 32'd1023);
  endtask

  task automatic build_chain();
    do_ack(10'd40, 8'h80, '0, 1'b0);
    do_ack(10'd35, 8'h60, '0, 1'b0);
    do_ack(10'd20, 8'h40, '0, 1'b0);
    do_ack(10'd36, 8'h20, '0, 1'b0);
  endtask

  task automatic t_unlink();
    build_chain();
    chk("R2 chain top", 32'(run_id), 32'd36);
    do_eoi(32'd35);
    chk("R8 walk busy", 32'(busy), 32'd1);
    wait_free();
    chk("R8 run kept after splice", 32'(run_id), 32'd36);
    chk("R8 prio kept after splice", 32'(run_prio), 32'h20);
    do_eoi(32'd45);
    wait_free();
    chk("R8 absent id no change", 32'(run_id), 32'd36);
    do_eoi(32'd36);
    chk("R7 pop to 20", 32'(run_id), 32'd20);
    chk("R7 pop prio 0x40", 32'(run_prio), 32'h40);
    do_eoi(32'd20);
    chk("R8 spliced entry skipped", 32'(run_id), 32'd40);
    chk("R8 spliced prio", 32'(run_prio), 32'h80);
    do_eoi(32'd40);
    chk("R7 chain drained", 32'(run_id), 32'd1023);
  endtask

  task automatic t_busy_ack();
    build_chain();
    do_eoi(32'd40);
    chk("R8 deep walk busy", 32'(busy), 32'd1);
    do_ack(10'd50, 8'h01, '0, 1'b0);
    chk("R9 ack while busy", ack_data, 32'd1023);
    chk("R9 run kept while busy", 32'(run_id), 32'd36);
    wait_free();
    do_eoi(32'd36);
    do_eoi(32'd20);
    chk("R8 pop reaches 35", 32'(run_id), 32'd35);
    do_eoi(32'd35);
    chk("R8 tail spliced to idle", 32'(run_id), 32'd1023);
    chk("R7 tail idle prio", 32'(run_prio), 32'h100);
  endtask

  initial begin
    for (int i = 0; i < NIRQ; i++) ptab[i] = 8'hFF;
    rst_n = 1'b0; ack_req = 1'b0; eoi_req = 1'b0; eoi_data = '0;
    hp_id = 10'd1023; hp_prio = 8'hFF; hp_line_high = 1'b0; hp_sgi_src = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_nest();
    t_level();
    t_sgi();
    t_unlink();
    t_busy_ack();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule